// File: doc/BRIEF.md
# Software-Triggered Transfer Start Register

This block lets the CPU start a data transfer controller from software. It keeps a byte-wide control register made of an enable flag in the top bit and a 7-bit vector number in the lower bits. Setting the flag from 0 to 1 launches one transfer. On that write the block forms a 16-bit vector fetch address and hands it to the transfer engine with a single-cycle request.

The block then tracks the transfer until the engine reports completion. What happens to the flag at that point depends on two inputs: a disable-after-end control bit supplied from outside, and a flag that says whether the transfer count has run out. The enable either drops on its own, or it stays set and an end interrupt is raised to the CPU. In the second case the CPU clears the enable by writing 0 to the disable-after-end bit. A hardware standby input forces everything back to the cleared state.

Top module: `swact_vector_ctrl`

## Requirements
- R1: After reset, `cpu_rdata_o` reads 0x00, and `act_req_o` and `end_irq_o` are low.
- R2: `standby_i` high at a clock edge clears the register to 0x00, drops `end_irq_o` and `act_req_o`, and clears `act_addr_o` to zero.
- R3: Bit 7 of `cpu_wdata_i` sets the enable when it is 1. Writing 0 to bit 7 never clears the enable.
- R4: Bits 6..0 take the written vector only when the enable reads 0 before the write, including the write that sets the enable. Otherwise they keep their value.
- R5: The request address is 0x0400 + (vector << 1). For example, vector 0x10 gives 0x0420 and vector 0x7F gives 0x04FE.
- R6: A write that moves the enable from 0 to 1 raises `act_req_o` for exactly one cycle, in the cycle after the write. The new address is on `act_addr_o` in that cycle and stays there until the next start.
- R7: A `xfer_done_i` pulse during a transfer, with `disel_i`=0 and `cnt_exhausted_i`=0, clears the enable. No interrupt is raised.
- R8: A `xfer_done_i` pulse during a transfer, with `disel_i`=1 or `cnt_exhausted_i`=1, keeps the enable at 1 and raises `end_irq_o`. `end_irq_o` stays high as long as the enable stays set.
- R9: While `end_irq_o` is high, a write of 0 to the disable-after-end bit (`disel_wr_i`=1, `disel_wdata_i`=0) clears the enable and drops `end_irq_o`. A write of 1 to that bit has no effect.
- R10: `xfer_done_i` is ignored when no transfer is in progress: when the block is idle, or when it is waiting after an end with the interrupt raised.
- R11: When a hardware clear (R7 or R9) and a CPU write fall in the same cycle, the clear wins. The enable reads 0 and the vector is unchanged.
- R12: `cpu_rdata_o` always shows the current register, with the enable in bit 7 and the vector in bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Hardware standby, clears all state |
| cpu_wr_i | input | 1 | CPU write strobe for the register |
| cpu_wdata_i | input | 8 | CPU write data: enable in bit 7, vector in bits 6..0 |
| cpu_rdata_o | output | 8 | Current register contents |
| xfer_done_i | input | 1 | Transfer-end strobe from the engine |
| cnt_exhausted_i | input | 1 | Transfer count has run out |
| disel_i | input | 1 | Current disable-after-end bit |
| disel_wr_i | input | 1 | Write strobe for the disable-after-end bit |
| disel_wdata_i | input | 1 | Value written to the disable-after-end bit |
| act_req_o | output | 1 | Single-cycle activation request |
| act_addr_o | output | 16 | Vector fetch address for the request |
| end_irq_o | output | 1 | End interrupt level to the CPU |

## Verification
The assertions check on every cycle the rules that relate the ports directly:
- the enable does not fall on a write of 0 (R3);
- the vector is frozen while the enable is set (R4);
- the request is one cycle long and matches the register's vector (R5, R6);
- the interrupt never stands without the enable (R8);
- standby and the clear through the disable-after-end bit take effect (R2, R9).

Only the bench's scenarios can show the rest. That includes which way a completion goes under each combination of the disable-after-end bit and the count-exhausted flag, done pulses arriving while idle or while already ended, and same-cycle collisions between CPU writes and hardware clears. A cycle-level model in the bench follows these scenarios across random and directed stimulus.

// File: rtl/swact_pkg.sv
package swact_pkg;
  localparam int unsigned VEC_W_DEF  = 7;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned SHIFT_DEF  = 1;
  localparam logic [15:0] BASE_DEF   = 16'h0400;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_ENDED = 2'd2
  } seq_state_e;
endpackage

// File: rtl/swact_rst_sync.sv
module swact_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/swact_vecreg.sv
module swact_vecreg #(
  parameter int unsigned VEC_W = 7,
  localparam int unsigned REG_W = VEC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hw_clr_i,
  output logic             en_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             start_o
);
  logic             en_q, en_d, en_ce;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_ce;
  logic             wr_open;

  always_comb begin
    wr_open = wr_i & ~en_q & ~hw_clr_i;
    start_o = wr_open & wdata_i[VEC_W] & ~standby_i;

    en_ce = standby_i | hw_clr_i | start_o;
    if (standby_i || hw_clr_i) en_d = 1'b0;
    else                       en_d = 1'b1;

    vec_ce = standby_i | wr_open;
    if (standby_i) vec_d = '0;
    else           vec_d = wdata_i[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (vec_ce) vec_q <= vec_d;
    end
  end

  assign en_o  = en_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/swact_seq.sv
module swact_seq
  import swact_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic start_i,
  input  logic done_i,
  input  logic exhausted_i,
  input  logic disel_i,
  input  logic disel_wr_i,
  input  logic disel_wdata_i,
  output logic hw_clr_o,
  output logic end_irq_o
);
  seq_state_e st_q, st_d;
  logic       done_clr, disel_clr, done_hold;

  always_comb begin
    done_clr  = (st_q == ST_BUSY) & done_i & ~disel_i & ~exhausted_i;
    done_hold = (st_q == ST_BUSY) & done_i & (disel_i | exhausted_i);
    disel_clr = (st_q == ST_ENDED) & disel_wr_i & ~disel_wdata_i;
    hw_clr_o  = done_clr | disel_clr;

    st_d = st_q;
    if (standby_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start_i) st_d = ST_BUSY;
        ST_BUSY: begin
          if (done_clr)       st_d = ST_IDLE;
          else if (done_hold) st_d = ST_ENDED;
        end
        ST_ENDED: if (disel_clr) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign end_irq_o = (st_q == ST_ENDED);
endmodule

// File: rtl/swact_addrgen.sv
module swact_addrgen #(
  parameter int unsigned VEC_W  = 7,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SHIFT  = 1,
  parameter logic [ADDR_W-1:0] BASE = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              req_q;
  logic [ADDR_W-1:0] addr_q, addr_d, offset;
  logic              addr_ce;

  always_comb begin
    offset  = ADDR_W'(vec_i) << SHIFT;
    addr_ce = standby_i | start_i;
    if (standby_i) addr_d = '0;
    else           addr_d = BASE + offset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= start_i & ~standby_i;
      if (addr_ce) addr_q <= addr_d;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/swact_vector_ctrl.sv
module swact_vector_ctrl
  import swact_pkg::*;
#(
  parameter int unsigned VEC_W  = VEC_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned SHIFT  = SHIFT_DEF,
  parameter logic [ADDR_W-1:0] BASE = BASE_DEF,
  localparam int unsigned REG_W = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              cpu_wr_i,
  input  logic [REG_W-1:0]  cpu_wdata_i,
  output logic [REG_W-1:0]  cpu_rdata_o,
  input  logic              xfer_done_i,
  input  logic              cnt_exhausted_i,
  input  logic              disel_i,
  input  logic              disel_wr_i,
  input  logic              disel_wdata_i,
  output logic              act_req_o,
  output logic [ADDR_W-1:0] act_addr_o,
  output logic              end_irq_o
);
  logic             srst_n;
  logic             en, start, hw_clr;
  logic [VEC_W-1:0] vec;

  swact_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  swact_vecreg #(.VEC_W(VEC_W)) u_reg (
    .clk       (clk),
    .rst_n     (srst_n),
    .standby_i (standby_i),
    .wr_i      (cpu_wr_i),
    .wdata_i   (cpu_wdata_i),
    .hw_clr_i  (hw_clr),
    .en_o      (en),
    .vec_o     (vec),
    .start_o   (start)
  );

  swact_seq u_seq (
    .clk           (clk),
    .rst_n         (srst_n),
    .standby_i     (standby_i),
    .start_i       (start),
    .done_i        (xfer_done_i),
    .exhausted_i   (cnt_exhausted_i),
    .disel_i       (disel_i),
    .disel_wr_i    (disel_wr_i),
    .disel_wdata_i (disel_wdata_i),
    .hw_clr_o      (hw_clr),
    .end_irq_o     (end_irq_o)
  );

  swact_addrgen #(
    .VEC_W  (VEC_W),
    .ADDR_W (ADDR_W),
    .SHIFT  (SHIFT),
    .BASE   (BASE)
  ) u_addr (
    .clk       (clk),
    .rst_n     (srst_n),
    .standby_i (standby_i),
    .start_i   (start),
    .vec_i     (cpu_wdata_i[VEC_W-1:0]),
    .req_o     (act_req_o),
    .addr_o    (act_addr_o)
  );

  assign cpu_rdata_o = {en, vec};
endmodule

// File: rtl/swact_vector_ctrl_chk.sv
module swact_vector_ctrl_chk #(
  parameter int unsigned VEC_W  = 7,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SHIFT  = 1,
  parameter logic [ADDR_W-1:0] BASE = 16'h0400,
  localparam int unsigned REG_W = VEC_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_i,
  input logic              cpu_wr_i,
  input logic [REG_W-1:0]  cpu_wdata_i,
  input logic [REG_W-1:0]  cpu_rdata_o,
  input logic              xfer_done_i,
  input logic              disel_wr_i,
  input logic              disel_wdata_i,
  input logic              act_req_o,
  input logic [ADDR_W-1:0] act_addr_o,
  input logic              end_irq_o
);
  p_standby_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (cpu_rdata_o == '0) && !end_irq_o && !act_req_o);

  p_zero_write_keeps_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_o[VEC_W] && cpu_wr_i && !cpu_wdata_i[VEC_W] && !xfer_done_i
    && !disel_wr_i && !standby_i |=> cpu_rdata_o[VEC_W]);

  p_vec_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_o[VEC_W] && !standby_i |=> cpu_rdata_o[VEC_W-1:0] == $past(cpu_rdata_o[VEC_W-1:0]));

  p_addr_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_req_o |-> act_addr_o == BASE + (ADDR_W'(cpu_rdata_o[VEC_W-1:0]) << SHIFT));

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_req_o |=> !act_req_o);

  p_req_with_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_req_o |-> cpu_rdata_o[VEC_W]);

  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq_o |-> cpu_rdata_o[VEC_W]);

  p_disel_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq_o && disel_wr_i && !disel_wdata_i |=> !cpu_rdata_o[VEC_W] && !end_irq_o);
endmodule

bind swact_vector_ctrl swact_vector_ctrl_chk #(
  .VEC_W  (VEC_W),
  .ADDR_W (ADDR_W),
  .SHIFT  (SHIFT),
  .BASE   (BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .standby_i     (standby_i),
  .cpu_wr_i      (cpu_wr_i),
  .cpu_wdata_i   (cpu_wdata_i),
  .cpu_rdata_o   (cpu_rdata_o),
  .xfer_done_i   (xfer_done_i),
  .disel_wr_i    (disel_wr_i),
  .disel_wdata_i (disel_wdata_i),
  .act_req_o     (act_req_o),
  .act_addr_o    (act_addr_o),
  .end_irq_o     (end_irq_o)
);

// File: tb/sim_swact_vector_ctrl.sv
module sim_swact_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby_i = 1'b0;
  logic        cpu_wr_i = 1'b0;
  logic [7:0]  cpu_wdata_i = '0;
  logic [7:0]  cpu_rdata_o;
  logic        xfer_done_i = 1'b0;
  logic        cnt_exhausted_i = 1'b0;
  logic        disel_i = 1'b0;
  logic        disel_wr_i = 1'b0;
  logic        disel_wdata_i = 1'b0;
  logic        act_req_o;
  logic [15:0] act_addr_o;
  logic        end_irq_o;

  int tests = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swact_vector_ctrl u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .standby_i       (standby_i),
    .cpu_wr_i        (cpu_wr_i),
    .cpu_wdata_i     (cpu_wdata_i),
    .cpu_rdata_o     (cpu_rdata_o),
    .xfer_done_i     (xfer_done_i),
    .cnt_exhausted_i (cnt_exhausted_i),
    .disel_i         (disel_i),
    .disel_wr_i      (disel_wr_i),
    .disel_wdata_i   (disel_wdata_i),
    .act_req_o       (act_req_o),
    .act_addr_o      (act_addr_o),
    .end_irq_o       (end_irq_o)
  );

  // reference model: m_st 0 idle, 1 transfer running, 2 ended with interrupt
  logic        m_en;
  logic [6:0]  m_vec;
  logic [1:0]  m_st;
  logic        m_req;
  logic [15:0] m_addr;

  function automatic logic [15:0] vec_addr(input logic [6:0] v);
    return 16'h0400 + {8'h00, v, 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 0; m_vec <= '0; m_st <= 0; m_req <= 0; m_addr <= '0;
    end else if (standby_i) begin
      m_en <= 0; m_vec <= '0; m_st <= 0; m_req <= 0; m_addr <= '0;
    end else begin
      logic clr, start, open;
      clr   = (m_st == 2'd1 && xfer_done_i && !disel_i && !cnt_exhausted_i)
            || (m_st == 2'd2 && disel_wr_i && !disel_wdata_i);
      open  = cpu_wr_i && !m_en && !clr;
      start = open && cpu_wdata_i[7];
      if (open) m_vec <= cpu_wdata_i[6:0];
      if (clr) m_en <= 0;
      else if (start) m_en <= 1;
      m_req <= start;
      if (start) m_addr <= vec_addr(cpu_wdata_i[6:0]);
      if (clr) m_st <= 0;
      else if (start) m_st <= 1;
      else if (m_st == 2'd1 && xfer_done_i) m_st <= 2;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R12 rdata", {24'h0, cpu_rdata_o}, {24'h0, m_en, m_vec});
    chk("R6 req", {31'h0, act_req_o}, {31'h0, m_req});
    chk("R5 addr", {16'h0, act_addr_o}, {16'h0, m_addr});
    chk("R8 irq", {31'h0, end_irq_o}, {31'h0, (m_st == 2'd2)});
  endtask

  task automatic cyc(input bit wr, input logic [7:0] wd, input bit dn, input bit ex,
                     input bit ds, input bit dw, input bit dwd, input bit sb);
    cpu_wr_i = wr; cpu_wdata_i = wd; xfer_done_i = dn; cnt_exhausted_i = ex;
    disel_i = ds; disel_wr_i = dw; disel_wdata_i = dwd; standby_i = sb;
    @(posedge clk); #1;
    cmp_model();
  endtask

  task automatic idle();
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle();

    // R1 reset state
    chk("R1 rdata", {24'h0, cpu_rdata_o}, 32'h0);
    chk("R1 req", {31'h0, act_req_o}, 32'h0);
    chk("R1 irq", {31'h0, end_irq_o}, 32'h0);

    // R5 R6 start with vector 0x10
    cyc(1, 8'h90, 0, 0, 0, 0, 0, 0);
    chk("R6 req pulse", {31'h0, act_req_o}, 32'h1);
    chk("R5 addr 0x10", {16'h0, act_addr_o}, 32'h0420);
    chk("R12 rdata after start", {24'h0, cpu_rdata_o}, 32'h90);
    idle();
    chk("R6 req one cycle", {31'h0, act_req_o}, 32'h0);

    // R3 R4 write of 0 with other vector while enabled
    cyc(1, 8'h05, 0, 0, 0, 0, 0, 0);
    chk("R3 R4 locked", {24'h0, cpu_rdata_o}, 32'h90);

    // R8 done with DISEL=1 holds enable, raises irq
    cyc(0, 8'h00, 1, 0, 1, 0, 0, 0);
    chk("R8 irq set", {31'h0, end_irq_o}, 32'h1);
    chk("R8 en held", {24'h0, cpu_rdata_o}, 32'h90);

    // R10 done while ended is ignored
    cyc(0, 8'h00, 1, 0, 0, 0, 0, 0);
    chk("R10 done ignored", {31'h0, end_irq_o}, 32'h1);

    // R9 DISEL write 1 no effect
    cyc(0, 8'h00, 0, 0, 1, 1, 1, 0);
    chk("R9 disel=1 no effect", {24'h0, cpu_rdata_o}, 32'h90);

    // R9 R11 DISEL write 0 with concurrent CPU write
    cyc(1, 8'hA3, 0, 0, 1, 1, 0, 0);
    chk("R9 clear", {24'h0, cpu_rdata_o}, 32'h10);
    chk("R9 irq drop", {31'h0, end_irq_o}, 32'h0);
    chk("R11 no start", {31'h0, act_req_o}, 32'h0);

    // R10 done while idle ignored
    cyc(0, 8'h00, 1, 1, 1, 0, 0, 0);
    chk("R10 idle done", {31'h0, end_irq_o}, 32'h0);

    // R5 top vector
    cyc(1, 8'hFF, 0, 0, 0, 0, 0, 0);
    chk("R5 addr 0x7F", {16'h0, act_addr_o}, 32'h04FE);

    // R7 R11 done clears, concurrent write ignored
    cyc(1, 8'h85, 1, 0, 0, 0, 0, 0);
    chk("R7 R11 cleared", {24'h0, cpu_rdata_o}, 32'h7F);
    chk("R7 no irq", {31'h0, end_irq_o}, 32'h0);
    idle();
    chk("R6 addr held", {16'h0, act_addr_o}, 32'h04FE);

    // R8 count exhausted with DISEL=0
    cyc(1, 8'h81, 0, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 1, 1, 0, 0, 0, 0);
    chk("R8 exhausted irq", {31'h0, end_irq_o}, 32'h1);

    // R2 standby
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 1);
    chk("R2 standby rdata", {24'h0, cpu_rdata_o}, 32'h0);
    chk("R2 standby irq", {31'h0, end_irq_o}, 32'h0);
    chk("R2 standby addr", {16'h0, act_addr_o}, 32'h0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit wr, dn, ex, ds, dw, dwd, sb;
      logic [7:0] wd;
      wr  = ($urandom % 100) < 30;
      wd  = 8'($urandom);
      dn  = ($urandom % 100) < 25;
      ex  = ($urandom % 100) < 30;
      ds  = ($urandom % 100) < 40;
      dw  = ($urandom % 100) < 20;
      dwd = ($urandom % 2) == 1;
      sb  = ($urandom % 100) < 2;
      cyc(wr, wd, dn, ex, ds, dw, dwd, sb);
    end

    finish_run();
  end
endmodule